// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block turns a 32-bit logical address into a physical address. It walks a tree of up to three translation tables that sit in ordinary memory. A requester presents the logical address and a supervisor flag. The block then picks one of two root pointers and fetches one descriptor per level through a single-word read port. It returns either the physical address or a fault indication, and reports completion with a one-cycle done pulse.

The table geometry is not fixed in hardware. A translation control word gives the number of top address bits to discard and the index width of each level, and the block samples that word when it accepts a request. Each descriptor's low two bits choose what the next step is. The walk can fetch a table of 4-byte descriptors or a table of 8-byte descriptors, it can stop early with a page descriptor, or it can fault. Several fields are bit-exact because the walker decodes them: the type code in bits 1:0, the control-word field positions and the supervisor-root enable at bit 25.

Top module: `xlat_table_walker`

## Requirements
- R1: The supervisor root (limit word and pointer) is used only when control bit 25 is 1 and the request's supervisor flag is 1. In every other case the CPU root is used.
- R2: The ignored-top-bits count comes from control bits 19:16, and the level A, B and C index widths come from bits 15:12, 11:8 and 7:4. A level's index is the logical address with its top (ignored count plus the widths of all earlier levels) bits removed, taking that level's width of bits. A width of 0 gives index 0.
- R3: A type code is the low two bits of the root limit word or of a descriptor: 0 is invalid, 1 is a page, 2 is a table of 4-byte descriptors, 3 is a table of 8-byte descriptors.
- R4: A fetch address is the table base plus the index times 4, or times 8 for 8-byte tables. The base is the root pointer with bits 1:0 cleared, or a descriptor with bits 3:0 cleared. Every fetch address is word-aligned.
- R5: In an 8-byte table the type is taken from the word at the entry address, and the next pointer or page base from the word at the entry address plus 4.
- R6: A page descriptor at any level ends the walk. The result is the descriptor with bits 7:0 cleared, plus the logical address with its top S bits cleared, where S is the ignored count plus the widths of all levels used so far, this one included.
- R7: At the last level (C) only a page descriptor is accepted. A table type there causes a fault.
- R8: An invalid descriptor at any level, or a root type of invalid or page, causes a fault. A root fault issues no memory read, and the physical address output reads 0 with the fault.
- R9: Done is high for exactly one cycle per accepted request, and fault is high only together with done. A request is accepted only while idle; a request presented while a walk is in progress is ignored and is not queued.
- R10: The read request and its address stay stable until the acknowledge arrives, and read data is taken in the acknowledge cycle.
- R11: After reset the block is idle, and done, fault, the read request and the physical address output are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation; taken only while idle |
| req_laddr | input | 32 | Logical address to translate |
| req_super | input | 1 | Request is in supervisor mode |
| ctl_word | input | 32 | Translation control word |
| sup_limit | input | 32 | Supervisor root limit word (type in bits 1:0) |
| sup_ptr | input | 32 | Supervisor root table pointer |
| cpu_limit | input | 32 | CPU root limit word (type in bits 1:0) |
| cpu_ptr | input | 32 | CPU root table pointer |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read acknowledge, read data valid |
| mem_rdata | input | 32 | Read data |
| idle | output | 1 | Walker can accept a request |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed (valid with done) |
| phys_addr | output | 32 | Translated address (valid with done) |

## Verification
The bench uses the default parameters: 32-bit addresses, three levels, 4-bit width fields, a page low-bit drop of 8, a table low-bit drop of 4 and a root low-bit drop of 2. With three levels, an early stop at level A and at level B can be reached, as can the last-level rule at C. The 4-bit fields let the bench change the control word between requests, with an ignored count of 0 or 4 and a zero width at level A, while the tables stay the same. The distinct drop values let the tests tell a root base from a descriptor base. Memory latency changes from request to request, which exercises the hold rule of the read port with waits of zero, one and two cycles.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // descriptor / root type code carried in bits 1:0
   typedef enum logic [1:0] {
      DT_INVALID = 2'd0,
      DT_PAGE    = 2'd1,
      DT_TBL4    = 2'd2,
      DT_TBL8    = 2'd3
   } dtype_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_W0   = 2'd1,   // entry word (or only word)
      ST_W1   = 2'd2    // second word of an 8-byte entry
   } wstate_e;

   // control word: supervisor-root enable bit
   localparam int CTL_SUP_EN_BIT = 25;

endpackage

// File: rtl/xlat_root_select.sv
module xlat_root_select
   import xlat_pkg::*;
#(
   parameter int AW        = 32,
   parameter int ROOT_DROP = 2
) (
   input  logic          sup_en,
   input  logic          req_super,
   input  logic [AW-1:0] sup_limit,
   input  logic [AW-1:0] sup_ptr,
   input  logic [AW-1:0] cpu_limit,
   input  logic [AW-1:0] cpu_ptr,
   output dtype_e        root_type,
   output logic [AW-1:0] root_base
);
   localparam logic [AW-1:0] KEEP = ~((AW)'((2 ** ROOT_DROP) - 1));

   logic use_sup;

   always_comb begin
      use_sup   = sup_en & req_super;
      root_type = use_sup ? dtype_e'(sup_limit[1:0]) : dtype_e'(cpu_limit[1:0]);
      root_base = (use_sup ? sup_ptr : cpu_ptr) & KEEP;
   end
endmodule

// File: rtl/xlat_level_index.sv
module xlat_level_index #(
   parameter int AW    = 32,
   parameter int FLD_W = 4,
   parameter int SW    = 8
) (
   input  logic [AW-1:0]    laddr,
   input  logic [SW-1:0]    lshift,
   input  logic [FLD_W-1:0] width,
   output logic [AW-1:0]    index
);
   logic [AW-1:0] dropped;
   logic [SW-1:0] rshift;

   always_comb begin
      dropped = laddr << lshift;
      rshift  = SW'(AW) - SW'(width);
      index   = (width == '0) ? '0 : (dropped >> rshift);
   end
endmodule

// File: rtl/xlat_page_offset.sv
module xlat_page_offset #(
   parameter int AW = 32,
   parameter int SW = 8
) (
   input  logic [AW-1:0] laddr,
   input  logic [SW-1:0] drop,
   output logic [AW-1:0] offset
);
   logic [AW-1:0] up;

   always_comb begin
      up     = laddr << drop;
      offset = up >> drop;
   end
endmodule

// File: rtl/xlat_table_walker.sv
module xlat_table_walker
   import xlat_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEVELS    = 3,
   parameter int FLD_W     = 4,
   parameter int PAGE_DROP = 8,
   parameter int TBL_DROP  = 4,
   parameter int ROOT_DROP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [31:0]   req_laddr,
   input  logic          req_super,
   input  logic [31:0]   ctl_word,
   input  logic [31:0]   sup_limit,
   input  logic [31:0]   sup_ptr,
   input  logic [31:0]   cpu_limit,
   input  logic [31:0]   cpu_ptr,
   output logic          mem_req,
   output logic [31:0]   mem_addr,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          idle,
   output logic          done,
   output logic          fault,
   output logic [31:0]   phys_addr
);
   localparam int SW      = $clog2((2 ** FLD_W) * (LEVELS + 1) + AW) + 1;
   localparam int LW      = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int IS_LSB  = 3 * FLD_W + FLD_W;
   localparam logic [AW-1:0] PAGE_KEEP = ~((AW)'((2 ** PAGE_DROP) - 1));
   localparam logic [AW-1:0] TBL_KEEP  = ~((AW)'((2 ** TBL_DROP) - 1));

   // elaboration-time parameter checks
   if (AW != 32) begin : g_chk_aw
      $error("xlat_table_walker: AW must be 32");
   end
   if (LEVELS < 1 || LEVELS > 3) begin : g_chk_lv
      $error("xlat_table_walker: LEVELS must be 1..3");
   end
   if (FLD_W < 1 || IS_LSB + FLD_W > CTL_SUP_EN_BIT) begin : g_chk_fw
      $error("xlat_table_walker: FLD_W fields overlap the root enable");
   end
   if (TBL_DROP < 2 || ROOT_DROP < 2 || PAGE_DROP < TBL_DROP) begin : g_chk_dr
      $error("xlat_table_walker: drop widths inconsistent");
   end

   wstate_e          state_q;
   logic [LW-1:0]    lvl_q;
   logic [AW-1:0]    base_q;
   logic             long_q;
   dtype_e           type_q;
   logic [AW-1:0]    laddr_q;
   logic [FLD_W-1:0] is_q;
   logic [FLD_W-1:0] wid_q [LEVELS];
   logic             done_q, fault_q;
   logic [AW-1:0]    phys_q;

   // root selection
   dtype_e        root_type;
   logic [AW-1:0] root_base;

   xlat_root_select #(.AW(AW), .ROOT_DROP(ROOT_DROP)) u_root (
      .sup_en    (ctl_word[CTL_SUP_EN_BIT]),
      .req_super (req_super),
      .sup_limit (sup_limit),
      .sup_ptr   (sup_ptr),
      .cpu_limit (cpu_limit),
      .cpu_ptr   (cpu_ptr),
      .root_type (root_type),
      .root_base (root_base)
   );

   // per-level index and page offset, in parallel
   logic [SW-1:0] cum     [LEVELS+1];
   logic [AW-1:0] idx_lvl [LEVELS];
   logic [AW-1:0] off_lvl [LEVELS];

   assign cum[0] = SW'(is_q);

   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      assign cum[k+1] = cum[k] + SW'(wid_q[k]);

      xlat_level_index #(.AW(AW), .FLD_W(FLD_W), .SW(SW)) u_idx (
         .laddr  (laddr_q),
         .lshift (cum[k]),
         .width  (wid_q[k]),
         .index  (idx_lvl[k])
      );

      xlat_page_offset #(.AW(AW), .SW(SW)) u_off (
         .laddr  (laddr_q),
         .drop   (cum[k+1]),
         .offset (off_lvl[k])
      );
   end

   logic [AW-1:0] idx_sel, off_sel, step, page_phys, next_base;
   dtype_e        desc_type;
   logic          last_lvl;

   always_comb begin
      idx_sel   = idx_lvl[lvl_q];
      off_sel   = off_lvl[lvl_q];
      step      = long_q ? (idx_sel << 3) : (idx_sel << 2);
      desc_type = (state_q == ST_W1) ? type_q : dtype_e'(mem_rdata[1:0]);
      page_phys = (mem_rdata & PAGE_KEEP) + off_sel;
      next_base = mem_rdata & TBL_KEEP;
      last_lvl  = (lvl_q == LW'(LEVELS - 1));
   end

   assign mem_req   = (state_q != ST_IDLE);
   assign mem_addr  = base_q + step + ((state_q == ST_W1) ? AW'(4) : AW'(0));
   assign idle      = (state_q == ST_IDLE);
   assign done      = done_q;
   assign fault     = fault_q;
   assign phys_addr = phys_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= '0;
         base_q  <= '0;
         long_q  <= 1'b0;
         type_q  <= DT_INVALID;
         laddr_q <= '0;
         is_q    <= '0;
         for (int k = 0; k < LEVELS; k++) wid_q[k] <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         phys_q  <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  laddr_q <= req_laddr;
                  is_q    <= ctl_word[IS_LSB +: FLD_W];
                  for (int k = 0; k < LEVELS; k++)
                     wid_q[k] <= ctl_word[(2 - k) * FLD_W + FLD_W +: FLD_W];
                  if (root_type == DT_INVALID || root_type == DT_PAGE) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     phys_q  <= '0;
                  end else begin
                     base_q  <= root_base;
                     long_q  <= (root_type == DT_TBL8);
                     lvl_q   <= '0;
                     state_q <= ST_W0;
                  end
               end
            end
            ST_W0, ST_W1: begin
               if (mem_ack) begin
                  if (state_q == ST_W0 && long_q) begin
                     type_q  <= dtype_e'(mem_rdata[1:0]);
                     state_q <= ST_W1;
                  end else begin
                     unique case (desc_type)
                        DT_PAGE: begin
                           done_q  <= 1'b1;
                           phys_q  <= page_phys;
                           state_q <= ST_IDLE;
                        end
                        DT_TBL4, DT_TBL8: begin
                           if (last_lvl) begin
                              done_q  <= 1'b1;
                              fault_q <= 1'b1;
                              phys_q  <= '0;
                              state_q <= ST_IDLE;
                           end else begin
                              base_q  <= next_base;
                              long_q  <= (desc_type == DT_TBL8);
                              lvl_q   <= lvl_q + 1'b1;
                              state_q <= ST_W0;
                           end
                        end
                        default: begin
                           done_q  <= 1'b1;
                           fault_q <= 1'b1;
                           phys_q  <= '0;
                           state_q <= ST_IDLE;
                        end
                     endcase
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_fault_has_done: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   a_r10_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (phys_addr == '0));

   a_r9_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !req_valid) |=> idle);

endmodule

// File: tb/tb_xlat_table_walker.sv
module tb_xlat_table_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_laddr = '0;
   logic        req_super = 1'b0;
   logic [31:0] ctl_word = '0;
   logic [31:0] sup_limit = 32'h0000_0003;
   logic [31:0] sup_ptr   = 32'h0000_020B;
   logic [31:0] cpu_limit = 32'h0000_0002;
   logic [31:0] cpu_ptr   = 32'h0000_0100;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        idle, done, fault;
   logic [31:0] phys_addr;

   always #2 clk = ~clk;   // 250 MHz

   xlat_table_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
      .req_super(req_super), .ctl_word(ctl_word), .sup_limit(sup_limit),
      .sup_ptr(sup_ptr), .cpu_limit(cpu_limit), .cpu_ptr(cpu_ptr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .idle(idle), .done(done), .fault(fault),
      .phys_addr(phys_addr)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [0:511];
   int          lat = 0;
   int          wait_cnt = 0;
   int          rd_cnt = 0;
   int          hold_err = 0;
   int          addr_err = 0;
   logic [31:0] held = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack  = 1'b0;
         wait_cnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt == 0) held = mem_addr;
         else if (mem_addr != held) hold_err++;
         if (mem_addr >= 32'h800 || mem_addr[1:0] != 2'b00) addr_err++;
         if (wait_cnt >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[10:2]];
            wait_cnt  = 0;
            rd_cnt++;
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic put(input logic [31:0] a, input logic [31:0] d);
      mem[a[10:2]] = d;
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic [31:0] ctl;
      logic        sup;
      logic [31:0] la;
      logic [31:0] phys;
      logic        flt;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{32'h0204_4440, 1'b0, 32'hF012_3456, 32'h1246_8A56, 1'b0, 4'd6},  // R6 page at A, R2 top bits ignored
      '{32'h0204_4440, 1'b0, 32'h010A_BCDE, 32'hABCA_BCDE, 1'b0, 4'd6},  // R6 page at B
      '{32'h0204_4440, 1'b0, 32'h0110_1234, 32'h5500_1234, 1'b0, 4'd6},  // R6 page at C, bits 7:0 dropped
      '{32'h0204_4440, 1'b0, 32'h0113_FFFF, 32'h7778_7EFF, 1'b0, 4'd2},  // R2 level C index 3
      '{32'h0204_4440, 1'b0, 32'h0111_0000, 32'h0000_0000, 1'b1, 4'd7},  // R7 table type at C
      '{32'h0204_4440, 1'b0, 32'h0112_0000, 32'h0000_0000, 1'b1, 4'd8},  // R8 invalid at C
      '{32'h0204_4440, 1'b0, 32'h0120_0000, 32'h0000_0000, 1'b1, 4'd8},  // R8 invalid at B
      '{32'h0204_4440, 1'b0, 32'h0200_0000, 32'h0000_0000, 1'b1, 4'd8},  // R8 invalid at A
      '{32'h0204_4440, 1'b0, 32'h0305_4321, 32'hCB03_5221, 1'b0, 4'd5},  // R5 8-byte page, type from word 0
      '{32'h0204_4440, 1'b0, 32'h0315_ABCD, 32'h0BAD_BBCD, 1'b0, 4'd5},  // R5 8-byte pointer from word 1
      '{32'h0204_4440, 1'b1, 32'h0076_5432, 32'h8076_5432, 1'b0, 4'd1},  // R1 supervisor root, R4 root base
      '{32'h0204_4440, 1'b1, 32'h0100_0000, 32'h0000_0000, 1'b1, 4'd8},  // R8 invalid in 8-byte root table
      '{32'h0004_4440, 1'b1, 32'h0076_5432, 32'h12AA_AA32, 1'b0, 4'd1},  // R1 enable clear -> CPU root
      '{32'h0204_4440, 1'b0, 32'h0076_5432, 32'h12AA_AA32, 1'b0, 4'd1},  // R1 user mode -> CPU root
      '{32'h0000_4440, 1'b0, 32'h1020_3040, 32'hABE0_3040, 1'b0, 4'd2},  // R2 ignored count 0
      '{32'h0004_0440, 1'b0, 32'h0312_3456, 32'h1546_8A56, 1'b0, 4'd2}   // R2 zero width at A
   };

   task automatic run(input logic [31:0] c, input logic s, input logic [31:0] a,
                      output logic [31:0] ph, output logic fl);
      int t;
      @(negedge clk);
      ctl_word  = c;
      req_super = s;
      req_laddr = a;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!done && t < 500) begin
         @(negedge clk);
         t++;
      end
      if (t >= 500) chk(1'b0, "R9 no done", 32'(t), 32'd500);
      ph = phys_addr;
      fl = fault;
      @(negedge clk);
      chk(done == 1'b0, "R9 done longer than one cycle", 32'(done), 32'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      logic [31:0] ph;
      logic        fl;
      int          rd0;
      int          extra;

      for (int i = 0; i < 512; i++) mem[i] = '0;
      // CPU root table A, 4-byte entries at 0x100
      put(32'h100, 32'h1234_5601);
      put(32'h104, 32'h0000_0302);
      put(32'h108, 32'h0000_0000);
      put(32'h10C, 32'h0000_03A3);
      // level B, 4-byte at 0x300
      put(32'h300, 32'hABC0_0001);
      put(32'h304, 32'h0000_0442);
      put(32'h308, 32'h0000_0000);
      // level C, 4-byte at 0x440
      put(32'h440, 32'h5500_0091);
      put(32'h444, 32'h0000_0502);
      put(32'h448, 32'h0000_0000);
      put(32'h44C, 32'h7777_7F01);
      // level B, 8-byte at 0x3A0
      put(32'h3A0, 32'h0000_0001);
      put(32'h3A4, 32'hCAFE_0F32);
      put(32'h3A8, 32'h0000_0002);
      put(32'h3AC, 32'h0000_0481);
      // level C, 4-byte at 0x480
      put(32'h494, 32'h0BAD_1001);
      // supervisor root table A, 8-byte at 0x208
      put(32'h208, 32'h0000_0001);
      put(32'h20C, 32'h8000_0000);
      put(32'h210, 32'h0000_0000);
      put(32'h214, 32'h0000_0301);

      repeat (3) @(negedge clk);
      // R11 reset state
      chk(idle == 1'b1, "R11 idle", 32'(idle), 32'd1);
      chk(done == 1'b0 && fault == 1'b0, "R11 done/fault", {30'd0, done, fault}, 32'd0);
      chk(mem_req == 1'b0, "R11 mem_req", 32'(mem_req), 32'd0);
      chk(phys_addr == '0, "R11 phys_addr", phys_addr, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table-driven walk
      for (int i = 0; i < NV; i++) begin
         lat = i % 3;
         run(VEC[i].ctl, VEC[i].sup, VEC[i].la, ph, fl);
         chk(fl == VEC[i].flt, $sformatf("R%0d vec %0d fault", VEC[i].req, i),
             32'(fl), 32'(VEC[i].flt));
         chk(ph == VEC[i].phys, $sformatf("R%0d vec %0d phys", VEC[i].req, i),
             ph, VEC[i].phys);
      end

      // R8 / R3: root type invalid, then page -> fault with no read
      lat = 0;
      cpu_limit = 32'h0000_0000;
      rd0 = rd_cnt;
      run(32'h0004_4440, 1'b0, 32'h0012_3456, ph, fl);
      chk(fl == 1'b1 && ph == '0, "R8 root invalid", ph, 32'd0);
      chk(rd_cnt == rd0, "R8 root invalid reads", 32'(rd_cnt - rd0), 32'd0);
      cpu_limit = 32'h0000_0001;
      rd0 = rd_cnt;
      run(32'h0004_4440, 1'b0, 32'h0012_3456, ph, fl);
      chk(fl == 1'b1, "R3 root page type faults", 32'(fl), 32'd1);
      chk(rd_cnt == rd0, "R3 root page reads", 32'(rd_cnt - rd0), 32'd0);
      cpu_limit = 32'h0000_0002;

      // R6 read count: three-level walk does exactly three fetches
      rd0 = rd_cnt;
      run(32'h0204_4440, 1'b0, 32'h0110_1234, ph, fl);
      chk(rd_cnt - rd0 == 3, "R6 three fetches", 32'(rd_cnt - rd0), 32'd3);

      // R9: request during a walk is ignored, not queued
      lat = 2;
      @(negedge clk);
      ctl_word  = 32'h0204_4440;
      req_super = 1'b0;
      req_laddr = 32'h0110_1234;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_laddr = 32'hF012_3456;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < 200 && !done; t++) @(negedge clk);
      chk(done == 1'b1 && phys_addr == 32'h5500_1234, "R9 busy request ignored",
          phys_addr, 32'h5500_1234);
      extra = 0;
      for (int t = 0; t < 30; t++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R9 no queued walk", 32'(extra), 32'd0);
      chk(idle == 1'b1, "R9 idle after walk", 32'(idle), 32'd1);

      // R10 / R4: port behaviour over all walks
      chk(hold_err == 0, "R10 address held until ack", 32'(hold_err), 32'd0);
      chk(addr_err == 0, "R4 fetch addresses aligned and in table area", 32'(addr_err), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule